// File: doc/BRIEF.md
# Amplifier Fault and Warning Pin Reporter

This block collects the protection and warning conditions of a multi-channel class-D output stage and turns them into status bits and two active-low open-drain status pins. One pin reports faults: overcurrent shutdown, DC offset, overtemperature shutdown, undervoltage and overvoltage. The other pin reports warnings: output clipping, global or per-channel overtemperature warning, current limiting, and the power-on event.

Clipping is not supplied from outside. The block detects it by counting, per channel, how many PWM cycles in a row the modulator has been at full duty. Fault status bits follow their live conditions. Warning status bits are sticky until a clear request arrives. A clear succeeds only for bits whose condition has gone away. Eight mask inputs hold off individual categories from the pins, but the status bits are unaffected.

Top module: `fault_warn_reporter`

## Requirements
- R1: A channel's clip status bit sets once that channel has had CLIP_RUN (default 20) PWM-cycle strobes in a row with its full-modulation flag high. The bit is visible two clock cycles after the strobe that completes the run. A run that is one strobe short sets nothing.
- R2: A PWM strobe with the full-modulation flag low restarts that channel's run from zero. Clock cycles without a strobe neither advance the run nor restart it.
- R3: While clip_en is low, no run is counted and no clip status bit can set.
- R4: The clip, global overtemperature warning, per-channel overtemperature warning and current-limit warning bits latch one cycle after their condition is seen. They stay set until clear_req is high in a cycle where that condition is inactive. A clear raised while the condition is still active leaves the bit set.
- R5: The fault status bits (overcurrent and DC offset per channel, overtemperature shutdown, undervoltage, overvoltage) equal their input condition one clock cycle later, with no latching.
- R6: fault_pull is 1 (fault_lvl low) when any unmasked fault status bit is set, and 0 otherwise. warn_pull is 1 (warn_lvl low) when any unmasked warning status bit is set, or when the power-on bit is set. fault_lvl and warn_lvl are always the inverse of the matching pull.
- R7: The pin_mask bits are: 0 overcurrent, 1 overtemperature shutdown, 2 undervoltage, 3 overvoltage, 4 DC offset, 5 current limit, 6 clip, 7 overtemperature warning. A mask bit of 1 removes its category from the pin only, and the status bits are unchanged.
- R8: A current-limit condition drives only the warning pin. It never drives the fault pin.
- R9: After reset the power-on status bit is 1, so warn_pull is 1. The bit has no mask, and a clear request resets it to 0.
- R10: After reset, every status bit other than the power-on bit is 0, every run count is zero, and fault_pull is 0.
- R11: Clip detection of each channel is independent: activity on one channel never sets another channel's clip bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_tick | input | 1 | One-cycle strobe per PWM cycle |
| full_mod | input | NUM_CH | Per-channel flag: current PWM cycle is at 100% duty |
| clip_en | input | 1 | Enables clip detection |
| oc_flt | input | NUM_CH | Per-channel overcurrent shutdown condition |
| dc_flt | input | NUM_CH | Per-channel DC offset condition |
| otsd_flt | input | 1 | Overtemperature shutdown condition |
| uv_flt | input | 1 | Undervoltage condition |
| ov_flt | input | 1 | Overvoltage condition |
| otw_glob | input | 1 | Global overtemperature warning condition |
| otw_ch | input | NUM_CH | Per-channel overtemperature warning condition |
| ilim_ch | input | NUM_CH | Per-channel current-limit condition |
| pin_mask | input | 8 | Pin mask bits, layout in R7 |
| clear_req | input | 1 | Clear request for sticky warning bits |
| st_oc | output | NUM_CH | Overcurrent status |
| st_dc | output | NUM_CH | DC offset status |
| st_otsd | output | 1 | Overtemperature shutdown status |
| st_uv | output | 1 | Undervoltage status |
| st_ov | output | 1 | Overvoltage status |
| st_clip | output | NUM_CH | Sticky clip status |
| st_otw_glob | output | 1 | Sticky global overtemperature warning |
| st_otw_ch | output | NUM_CH | Sticky per-channel overtemperature warning |
| st_ilim | output | NUM_CH | Sticky current-limit warning |
| st_por | output | 1 | Sticky power-on status |
| fault_pull | output | 1 | Fault pin pull-down enable |
| warn_pull | output | 1 | Warning pin pull-down enable |
| fault_lvl | output | 1 | Fault pin level, weak high when released |
| warn_lvl | output | 1 | Warning pin level, weak high when released |

## Verification
The bench builds the block with its defaults, NUM_CH of 2 and CLIP_RUN of 20. This is small enough to sweep every run length from 0 to 23 on one channel and land exactly on both sides of the clip threshold. The two channels are few enough that every fault source and every warning source is driven one at a time with its mask both clear and set. Each pin and status bit is computed arithmetically from the source index and mask value. Clears are issued with the condition both held and removed.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam int MASK_W    = 8;
  localparam int MSK_OC    = 0;
  localparam int MSK_OTSD  = 1;
  localparam int MSK_UV    = 2;
  localparam int MSK_OV    = 3;
  localparam int MSK_DC    = 4;
  localparam int MSK_ILIM  = 5;
  localparam int MSK_CLIP  = 6;
  localparam int MSK_OTW   = 7;
endpackage

// File: rtl/fwr_rst_sync.sv
module fwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fwr_clip_run.sv
module fwr_clip_run #(
  parameter int CLIP_RUN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic full,
  input  logic en,
  output logic clip
);
  localparam int CW = $clog2(CLIP_RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(CLIP_RUN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!full)              cnt_d = '0;
      else if (cnt_q != RUN_C) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign clip = (cnt_q == RUN_C);

  // R2: a strobe without full modulation restarts the run
  a_r2_gap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !full) |=> (cnt_q == '0));
  // R1: one step short of the run, a further full strobe completes it
  a_r1_run_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && full && cnt_q == RUN_C - 1'b1) |=> clip);
  // R3: disabled detection keeps the run at zero
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clip);
endmodule

// File: rtl/fwr_sticky.sv
module fwr_sticky #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb begin
    st_d = cond | (st_q & {W{~clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {W{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q = st_q;

  // R4: a set bit is kept while no clear is requested
  a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((st_q & $past(st_q)) == $past(st_q)));
  // R4: an active condition always leaves its bit set, clear or not
  a_r4_active_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(cond)) == $past(cond)));
endmodule

// File: rtl/fault_warn_reporter.sv
module fault_warn_reporter
  import fwr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CLIP_RUN = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwm_tick,
  input  logic [NUM_CH-1:0]   full_mod,
  input  logic                clip_en,
  input  logic [NUM_CH-1:0]   oc_flt,
  input  logic [NUM_CH-1:0]   dc_flt,
  input  logic                otsd_flt,
  input  logic                uv_flt,
  input  logic                ov_flt,
  input  logic                otw_glob,
  input  logic [NUM_CH-1:0]   otw_ch,
  input  logic [NUM_CH-1:0]   ilim_ch,
  input  logic [MASK_W-1:0]   pin_mask,
  input  logic                clear_req,
  output logic [NUM_CH-1:0]   st_oc,
  output logic [NUM_CH-1:0]   st_dc,
  output logic                st_otsd,
  output logic                st_uv,
  output logic                st_ov,
  output logic [NUM_CH-1:0]   st_clip,
  output logic                st_otw_glob,
  output logic [NUM_CH-1:0]   st_otw_ch,
  output logic [NUM_CH-1:0]   st_ilim,
  output logic                st_por,
  output logic                fault_pull,
  output logic                warn_pull,
  output logic                fault_lvl,
  output logic                warn_lvl
);
  localparam int FW = 2 * NUM_CH + 3;
  localparam int OW = NUM_CH + 1;

  logic rst_s_n;

  fwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // live fault status, one register stage
  logic [FW-1:0] flt_q;
  logic [FW-1:0] flt_d;

  always_comb begin
    flt_d = {oc_flt, dc_flt, otsd_flt, uv_flt, ov_flt};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) flt_q <= '0;
    else          flt_q <= flt_d;
  end

  assign {st_oc, st_dc, st_otsd, st_uv, st_ov} = flt_q;

  // clip run detectors
  logic [NUM_CH-1:0] clip_cond;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clip
    fwr_clip_run #(.CLIP_RUN(CLIP_RUN)) u_run (
      .clk   (clk),
      .rst_n (rst_s_n),
      .tick  (pwm_tick),
      .full  (full_mod[ch]),
      .en    (clip_en),
      .clip  (clip_cond[ch])
    );
  end

  // sticky warnings
  logic [OW-1:0] otw_q;

  fwr_sticky #(.W(NUM_CH), .RST_VAL(1'b0)) u_clip_st (
    .clk (clk), .rst_n (rst_s_n), .cond (clip_cond), .clr (clear_req), .q (st_clip)
  );
  fwr_sticky #(.W(OW), .RST_VAL(1'b0)) u_otw_st (
    .clk (clk), .rst_n (rst_s_n), .cond ({otw_ch, otw_glob}), .clr (clear_req), .q (otw_q)
  );
  fwr_sticky #(.W(NUM_CH), .RST_VAL(1'b0)) u_ilim_st (
    .clk (clk), .rst_n (rst_s_n), .cond (ilim_ch), .clr (clear_req), .q (st_ilim)
  );
  fwr_sticky #(.W(1), .RST_VAL(1'b1)) u_por_st (
    .clk (clk), .rst_n (rst_s_n), .cond (1'b0), .clr (clear_req), .q (st_por)
  );

  assign {st_otw_ch, st_otw_glob} = otw_q;

  // pin combination
  logic fault_any;
  logic warn_any;

  always_comb begin
    fault_any = ((|st_oc) & ~pin_mask[MSK_OC])
              | (st_otsd  & ~pin_mask[MSK_OTSD])
              | (st_uv    & ~pin_mask[MSK_UV])
              | (st_ov    & ~pin_mask[MSK_OV])
              | ((|st_dc) & ~pin_mask[MSK_DC]);
    warn_any  = ((|st_clip) & ~pin_mask[MSK_CLIP])
              | ((st_otw_glob | (|st_otw_ch)) & ~pin_mask[MSK_OTW])
              | ((|st_ilim) & ~pin_mask[MSK_ILIM])
              | st_por;
  end

  assign fault_pull = fault_any;
  assign warn_pull  = warn_any;
  assign fault_lvl  = ~fault_pull;
  assign warn_lvl   = ~warn_pull;

  // R6: no fault status means the fault pin is released
  a_r6_fault_released: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_oc == '0 && st_dc == '0 && !st_otsd && !st_uv && !st_ov) |-> !fault_pull);
  // R7: all fault categories masked keeps the fault pin released
  a_r7_fault_all_masked: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pin_mask[MSK_OC] && pin_mask[MSK_OTSD] && pin_mask[MSK_UV] &&
     pin_mask[MSK_OV] && pin_mask[MSK_DC]) |-> !fault_pull);
  // R9: power-on status always pulls the warning pin
  a_r9_por_pulls_warn: assert property (@(posedge clk) disable iff (!rst_s_n)
    st_por |-> warn_pull);
  // R8: current limiting never reaches the fault pin
  a_r8_ilim_not_fault: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_ilim != '0 && st_oc == '0 && st_dc == '0 && !st_otsd && !st_uv && !st_ov)
    |-> !fault_pull);
  // R6: the pin level is the inverse of its pull enable
  a_r6_level_inverse: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fault_lvl != fault_pull) && (warn_lvl != warn_pull));
endmodule

// File: tb/sim_fault_warn_reporter.sv
module sim_fault_warn_reporter;
  localparam int NC  = 2;
  localparam int RUN = 20;

  logic          clk;
  logic          rst_n;
  logic          pwm_tick;
  logic [NC-1:0] full_mod;
  logic          clip_en;
  logic [NC-1:0] oc_flt, dc_flt, otw_ch, ilim_ch;
  logic          otsd_flt, uv_flt, ov_flt, otw_glob;
  logic [7:0]    pin_mask;
  logic          clear_req;
  logic [NC-1:0] st_oc, st_dc, st_clip, st_otw_ch, st_ilim;
  logic          st_otsd, st_uv, st_ov, st_otw_glob, st_por;
  logic          fault_pull, warn_pull, fault_lvl, warn_lvl;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  fault_warn_reporter #(.NUM_CH(NC), .CLIP_RUN(RUN)) u0 (
    .clk (clk), .rst_n (rst_n), .pwm_tick (pwm_tick), .full_mod (full_mod),
    .clip_en (clip_en), .oc_flt (oc_flt), .dc_flt (dc_flt), .otsd_flt (otsd_flt),
    .uv_flt (uv_flt), .ov_flt (ov_flt), .otw_glob (otw_glob), .otw_ch (otw_ch),
    .ilim_ch (ilim_ch), .pin_mask (pin_mask), .clear_req (clear_req),
    .st_oc (st_oc), .st_dc (st_dc), .st_otsd (st_otsd), .st_uv (st_uv), .st_ov (st_ov),
    .st_clip (st_clip), .st_otw_glob (st_otw_glob), .st_otw_ch (st_otw_ch),
    .st_ilim (st_ilim), .st_por (st_por), .fault_pull (fault_pull),
    .warn_pull (warn_pull), .fault_lvl (fault_lvl), .warn_lvl (warn_lvl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input logic [NC-1:0] f);
    @(negedge clk);
    pwm_tick = 1'b1;
    full_mod = f;
    @(negedge clk);
    pwm_tick = 1'b0;
    full_mod = '0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
  endtask

  // fault source index: 0 oc0, 1 oc1, 2 dc0, 3 dc1, 4 otsd, 5 uv, 6 ov
  function automatic int fault_mask_bit(input int s);
    if (s < 2) return 0;
    if (s < 4) return 4;
    if (s == 4) return 1;
    if (s == 5) return 2;
    return 3;
  endfunction

  task automatic set_fault(input int s, input logic v);
    case (s)
      0: oc_flt[0] = v;
      1: oc_flt[1] = v;
      2: dc_flt[0] = v;
      3: dc_flt[1] = v;
      4: otsd_flt = v;
      5: uv_flt = v;
      default: ov_flt = v;
    endcase
  endtask

  function automatic int fault_stat(input int s);
    case (s)
      0: return int'(st_oc[0]);
      1: return int'(st_oc[1]);
      2: return int'(st_dc[0]);
      3: return int'(st_dc[1]);
      4: return int'(st_otsd);
      5: return int'(st_uv);
      default: return int'(st_ov);
    endcase
  endfunction

  // warning source index: 0 otw_glob, 1 otw_ch0, 2 otw_ch1, 3 ilim0, 4 ilim1
  task automatic set_warn(input int s, input logic v);
    case (s)
      0: otw_glob = v;
      1: otw_ch[0] = v;
      2: otw_ch[1] = v;
      3: ilim_ch[0] = v;
      default: ilim_ch[1] = v;
    endcase
  endtask

  function automatic int warn_stat(input int s);
    case (s)
      0: return int'(st_otw_glob);
      1: return int'(st_otw_ch[0]);
      2: return int'(st_otw_ch[1]);
      3: return int'(st_ilim[0]);
      default: return int'(st_ilim[1]);
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_tick = 1'b0; full_mod = '0; clip_en = 1'b1;
    oc_flt = '0; dc_flt = '0; otsd_flt = 1'b0; uv_flt = 1'b0; ov_flt = 1'b0;
    otw_glob = 1'b0; otw_ch = '0; ilim_ch = '0; pin_mask = '0; clear_req = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R10 / R9: reset state
    chk("R10 reset clip", int'(st_clip), 0);
    chk("R10 reset warn bits", int'({st_otw_glob, st_otw_ch, st_ilim}), 0);
    chk("R10 reset fault bits", int'({st_oc, st_dc, st_otsd, st_uv, st_ov}), 0);
    chk("R10 fault pin released", int'(fault_pull), 0);
    chk("R9 por set after reset", int'(st_por), 1);
    chk("R9 warn pulled by por", int'(warn_pull), 1);
    chk("R6 warn level low", int'(warn_lvl), 0);
    pin_mask = 8'hFF;
    step(1);
    chk("R9 por not maskable", int'(warn_pull), 1);
    pin_mask = 8'h00;
    do_clear();
    chk("R9 por cleared", int'(st_por), 0);
    chk("R9 warn released", int'(warn_pull), 0);

    // R1 / R2 / R11: run-length sweep on channel 0
    for (int n = 0; n <= RUN + 3; n++) begin
      tick(2'b00);
      do_clear();
      for (int k = 0; k < n; k++) tick(2'b01);
      step(1);
      chk($sformatf("R1 clip after run %0d", n), int'(st_clip[0]), (n >= RUN) ? 1 : 0);
      chk("R11 other channel idle", int'(st_clip[1]), 0);
      chk("R6 warn from clip", int'(warn_pull), (n >= RUN) ? 1 : 0);
    end
    tick(2'b00);
    do_clear();
    chk("R4 clip cleared after run broken", int'(st_clip[0]), 0);

    // R4: clear while the run is still active keeps the bit
    for (int k = 0; k < RUN; k++) tick(2'b10);
    step(1);
    do_clear();
    chk("R4 clear while clipping", int'(st_clip[1]), 1);
    chk("R11 ch0 untouched", int'(st_clip[0]), 0);
    tick(2'b00);
    do_clear();
    chk("R4 clip clear after gap", int'(st_clip[1]), 0);

    // R2: non-strobe cycles do not break the run; one gap strobe restarts it
    for (int k = 0; k < RUN - 1; k++) begin
      tick(2'b01);
      step(2);
    end
    tick(2'b00);
    tick(2'b01);
    step(1);
    chk("R2 gap strobe restarts run", int'(st_clip[0]), 0);
    for (int k = 0; k < RUN - 2; k++) tick(2'b01);
    step(3);
    chk("R2 idle cycles keep run", int'(st_clip[0]), 0);
    tick(2'b01);
    step(1);
    chk("R2 run of idle-spaced strobes", int'(st_clip[0]), 1);
    tick(2'b00);
    do_clear();

    // R7: clip mask hides pin, keeps status
    for (int k = 0; k < RUN; k++) tick(2'b01);
    pin_mask = 8'h40;
    step(1);
    chk("R7 clip masked status", int'(st_clip[0]), 1);
    chk("R7 clip masked pin", int'(warn_pull), 0);
    pin_mask = 8'h00;
    step(1);
    chk("R7 clip unmasked pin", int'(warn_pull), 1);
    tick(2'b00);
    do_clear();

    // R3: detection disabled
    clip_en = 1'b0;
    for (int k = 0; k < RUN + 4; k++) tick(2'b11);
    step(1);
    chk("R3 disabled no clip", int'(st_clip), 0);
    clip_en = 1'b1;
    for (int k = 0; k < RUN - 1; k++) tick(2'b11);
    step(1);
    chk("R3 re-enabled counts from zero", int'(st_clip), 0);
    tick(2'b11);
    step(1);
    chk("R3 re-enabled full run", int'(st_clip), 3);
    tick(2'b00);
    do_clear();

    // R5 / R6 / R7: each fault source with mask clear and set
    for (int s = 0; s < 7; s++) begin
      for (int m = 0; m < 2; m++) begin
        pin_mask = 8'(m << fault_mask_bit(s));
        @(negedge clk);
        set_fault(s, 1'b1);
        step(1);
        chk($sformatf("R5 fault %0d status m%0d", s, m), fault_stat(s), 1);
        chk($sformatf("R7 fault %0d pin m%0d", s, m), int'(fault_pull), 1 - m);
        chk("R6 fault level", int'(fault_lvl), m);
        chk("R6 fault not on warn", int'(warn_pull), 0);
        set_fault(s, 1'b0);
        step(1);
        chk($sformatf("R5 fault %0d follows release", s), fault_stat(s), 0);
        chk("R6 fault pin released", int'(fault_pull), 0);
      end
    end
    pin_mask = '0;

    // R4 / R7 / R8: each warning source with mask clear and set
    for (int s = 0; s < 5; s++) begin
      for (int m = 0; m < 2; m++) begin
        pin_mask = 8'(m << ((s < 3) ? 7 : 5));
        @(negedge clk);
        set_warn(s, 1'b1);
        step(1);
        set_warn(s, 1'b0);
        step(2);
        chk($sformatf("R4 warn %0d sticky m%0d", s, m), warn_stat(s), 1);
        chk($sformatf("R7 warn %0d pin m%0d", s, m), int'(warn_pull), 1 - m);
        chk($sformatf("R8 warn %0d no fault pin", s), int'(fault_pull), 0);
        do_clear();
        chk($sformatf("R4 warn %0d cleared", s), warn_stat(s), 0);
      end
    end
    pin_mask = '0;

    // R4: clear while condition held
    @(negedge clk);
    otw_glob = 1'b1;
    step(1);
    do_clear();
    chk("R4 clear with otw held", int'(st_otw_glob), 1);
    otw_glob = 1'b0;
    do_clear();
    chk("R4 clear after otw gone", int'(st_otw_glob), 0);

    // R8: current limit with fault mask set does not touch fault pin
    @(negedge clk);
    ilim_ch = 2'b11;
    step(1);
    chk("R8 ilim warn pin", int'(warn_pull), 1);
    chk("R8 ilim fault pin", int'(fault_pull), 0);
    ilim_ch = '0;
    do_clear();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule